// File: doc/BRIEF.md
# Bus Chip-Select Decoder with Interrupt-Acknowledge Blocking

This block turns the address, strobe, read/write and function-code lines of a small processor bus (20-bit address, 8-bit data) into active-low select lines for one flash ROM and two RAM banks. It is purely combinational. Every select follows the bus inputs with no register in the path.

The flash gets its chip select and output enable on separate pins. A read drives both low. A write drives only the chip select low and keeps the output enable high, so the flash can latch the write data. A small detector flags every cycle whose function code is all ones, which is how the processor marks an interrupt-acknowledge cycle. That flag blocks the ROM decode, so the ROM never drives the data bus while the processor fetches a vector from the top of the address map.

The ROM sits in the top 128 KB of the map. The RAM starts at address zero and is split into two equal banks. A build parameter picks one of three RAM sizes.

Top module: `bus_select_decoder`

## Requirements
- R1: While `as_ni` is high, all four select outputs are high, whatever the other inputs are.
- R2: With `as_ni` low, `rw_i` = 1 (read), an address in 0xE0000..0xFFFFF and a function code other than 3'b111, both `rom_cs_no` and `rom_oe_no` are low.
- R3: With `as_ni` low, `rw_i` = 0 (write), an address in 0xE0000..0xFFFFF and a function code other than 3'b111, `rom_cs_no` is low and `rom_oe_no` stays high.
- R4: While `fc_i` = 3'b111, `rom_cs_no` and `rom_oe_no` stay high for every address and direction. This includes the acknowledge address (A19..A4 all ones, with the level on A3..A1).
- R5: With `as_ni` low, `ram_cs_no[0]` is low exactly when the address is below the bank size, for reads and writes and for any function code.
- R6: With `as_ni` low, `ram_cs_no[1]` is low exactly when the address is at or above the bank size and below the RAM top, for reads and writes and for any function code.
- R7: `RAM_CFG` sets the sizes. 0 gives a 32 KB bank and a 64 KB top. 1 gives a 128 KB bank and a 256 KB top. 2 gives a 512 KB bank and a top of 0xE0000, so bank 1 stops below the ROM.
- R8: An address between the RAM top and 0xE0000 asserts no select.
- R9: At most one of `rom_cs_no`, `ram_cs_no[0]` and `ram_cs_no[1]` is low at any time, and `rom_oe_no` is low only while `rom_cs_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 20 | Byte address A19..A0 |
| as_ni | input | 1 | Address strobe, active low |
| rw_i | input | 1 | Direction, 1 = read, 0 = write |
| fc_i | input | 3 | Function code FC2..FC0 |
| rom_cs_no | output | 1 | Flash chip select, active low |
| rom_oe_no | output | 1 | Flash output enable, active low |
| ram_cs_no | output | 2 | RAM bank selects, bit b selects bank b, active low |

## Verification
An interrupt-acknowledge cycle and a ROM decode can happen in the same cycle. The acknowledge address lies inside the ROM window, so the blocking flag and the ROM range match are both true at once. The bench provokes this by running reads and writes with `fc_i` = 3'b111 at the acknowledge addresses for every interrupt level, and at other ROM addresses. It judges these cycles against its model: no ROM line may drop, and the RAM selects must still follow the address alone. It also runs `fc_i` = 3'b110 at the same addresses, where the ROM must respond. This shows the blocking depends on all three function-code bits.

// File: rtl/bsd_pkg.sv
`timescale 1ns/1ps
package bsd_pkg;

  typedef enum int unsigned {
    RAM_64K  = 0,
    RAM_256K = 1,
    RAM_896K = 2
  } ram_cfg_e;

  localparam int unsigned ROM_BYTES = 32'h2_0000;

  // size of one RAM bank in bytes
  function automatic int unsigned bank_bytes(int unsigned cfg);
    case (cfg)
      RAM_64K:  return 32'h0_8000;
      RAM_256K: return 32'h2_0000;
      default:  return 32'h8_0000;
    endcase
  endfunction

  // first byte above RAM; the largest build is clipped at the ROM base
  function automatic int unsigned ram_top(int unsigned cfg, int unsigned rom_base);
    int unsigned t;
    t = 2 * bank_bytes(cfg);
    return (t > rom_base) ? rom_base : t;
  endfunction

endpackage

// File: rtl/bsd_iack_detect.sv
`timescale 1ns/1ps
module bsd_iack_detect #(
  parameter int unsigned FC_W = 3
) (
  input  logic [FC_W-1:0] fc_i,
  output logic            cpu_space_o
);
  assign cpu_space_o = &fc_i;
endmodule

// File: rtl/bsd_region_match.sv
`timescale 1ns/1ps
module bsd_region_match #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned LO     = 0,
  parameter int unsigned HI     = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI);

  logic lo_ok, hi_ok;

  generate
    if (LO == 0) begin : g_lo_open
      assign lo_ok = 1'b1;
    end else begin : g_lo_cmp
      assign lo_ok = (addr_i >= LO_A);
    end
    if (HI_A == {ADDR_W{1'b1}}) begin : g_hi_open
      assign hi_ok = 1'b1;
    end else begin : g_hi_cmp
      assign hi_ok = (addr_i <= HI_A);
    end
  endgenerate

  assign hit_o = lo_ok & hi_ok;
endmodule

// File: rtl/bsd_rom_ctrl.sv
`timescale 1ns/1ps
module bsd_rom_ctrl (
  input  logic hit_i,
  input  logic cycle_i,
  input  logic rd_i,
  input  logic block_i,
  output logic cs_no,
  output logic oe_no
);
  logic sel;
  assign sel   = hit_i & cycle_i & ~block_i;
  assign cs_no = ~sel;
  // writes keep the output driver off so the flash can take data
  assign oe_no = ~(sel & rd_i);
endmodule

// File: rtl/bus_select_decoder.sv
`timescale 1ns/1ps
module bus_select_decoder #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned FC_W    = 3,
  parameter int unsigned RAM_CFG = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              as_ni,
  input  logic              rw_i,
  input  logic [FC_W-1:0]   fc_i,
  output logic              rom_cs_no,
  output logic              rom_oe_no,
  output logic [1:0]        ram_cs_no
);
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned SPACE     = 1 << ADDR_W;
  localparam int unsigned ROM_BASE  = SPACE - bsd_pkg::ROM_BYTES;
  localparam int unsigned BANK      = bsd_pkg::bank_bytes(RAM_CFG);
  localparam int unsigned TOP       = bsd_pkg::ram_top(RAM_CFG, ROM_BASE);

  logic cycle_on;
  logic cpu_space;
  logic rom_hit;
  logic [NUM_BANKS-1:0] bank_hit;

  assign cycle_on = ~as_ni;

  bsd_iack_detect #(.FC_W(FC_W)) u_iack (
    .fc_i        (fc_i),
    .cpu_space_o (cpu_space)
  );

  bsd_region_match #(.ADDR_W(ADDR_W), .LO(ROM_BASE), .HI(SPACE - 1)) u_rom_match (
    .addr_i (addr_i),
    .hit_o  (rom_hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned B_LO = b * BANK;
    localparam int unsigned B_HI = (b == NUM_BANKS - 1) ? TOP - 1 : (b + 1) * BANK - 1;
    bsd_region_match #(.ADDR_W(ADDR_W), .LO(B_LO), .HI(B_HI)) u_match (
      .addr_i (addr_i),
      .hit_o  (bank_hit[b])
    );
    assign ram_cs_no[b] = ~(cycle_on & bank_hit[b]);
  end

  bsd_rom_ctrl u_rom (
    .hit_i   (rom_hit),
    .cycle_i (cycle_on),
    .rd_i    (rw_i),
    .block_i (cpu_space),
    .cs_no   (rom_cs_no),
    .oe_no   (rom_oe_no)
  );
endmodule

// File: rtl/bus_select_decoder_chk.sv
`timescale 1ns/1ps
module bus_select_decoder_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned FC_W   = 3
) (
  input logic [ADDR_W-1:0] addr_i,
  input logic              as_ni,
  input logic              rw_i,
  input logic [FC_W-1:0]   fc_i,
  input logic              rom_cs_no,
  input logic              rom_oe_no,
  input logic [1:0]        ram_cs_no
);
  logic known;
  assign known = !$isunknown({addr_i, as_ni, rw_i, fc_i, rom_cs_no, rom_oe_no, ram_cs_no});

  always_comb begin
    if (known) begin
      // R1
      a_r1_idle_quiet: assert (!as_ni || (rom_cs_no && rom_oe_no && ram_cs_no == 2'b11));
      // R4
      a_r4_iack_blocks_rom: assert (!(&fc_i) || (rom_cs_no && rom_oe_no));
      // R3
      a_r3_write_no_oe: assert (rw_i || rom_oe_no);
      // R9
      a_r9_one_select: assert ($countones({~rom_cs_no, ~ram_cs_no}) <= 1);
      a_r9_oe_needs_cs: assert (rom_oe_no || !rom_cs_no);
    end
  end
endmodule

bind bus_select_decoder bus_select_decoder_chk #(.ADDR_W(ADDR_W), .FC_W(FC_W)) u_chk (
  .addr_i    (addr_i),
  .as_ni     (as_ni),
  .rw_i      (rw_i),
  .fc_i      (fc_i),
  .rom_cs_no (rom_cs_no),
  .rom_oe_no (rom_oe_no),
  .ram_cs_no (ram_cs_no)
);

// File: tb/sim_bus_select_decoder.sv
`timescale 1ns/1ps
module sim_bus_select_decoder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [19:0] addr;
  logic        as_n;
  logic        rw;
  logic [2:0]  fc;

  logic [3:0] got [3];
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  bus_select_decoder #(.RAM_CFG(0)) u0 (.addr_i(addr), .as_ni(as_n), .rw_i(rw), .fc_i(fc),
    .rom_cs_no(got[0][3]), .rom_oe_no(got[0][2]), .ram_cs_no(got[0][1:0]));
  bus_select_decoder #(.RAM_CFG(1)) u1 (.addr_i(addr), .as_ni(as_n), .rw_i(rw), .fc_i(fc),
    .rom_cs_no(got[1][3]), .rom_oe_no(got[1][2]), .ram_cs_no(got[1][1:0]));
  bus_select_decoder #(.RAM_CFG(2)) u2 (.addr_i(addr), .as_ni(as_n), .rw_i(rw), .fc_i(fc),
    .rom_cs_no(got[2][3]), .rom_oe_no(got[2][2]), .ram_cs_no(got[2][1:0]));

  // reference: {rom_cs_n, rom_oe_n, ram1_n, ram0_n}
  function automatic logic [3:0] model(int cfg, int a, bit s_n, bit r, int f);
    int bank, top;
    logic [3:0] o;
    o = 4'b1111;
    if (cfg == 0) begin bank = 'h8000;  top = 'h10000; end
    else if (cfg == 1) begin bank = 'h20000; top = 'h40000; end
    else begin bank = 'h80000; top = 'hE0000; end
    if (!s_n) begin
      if (a < bank) o[0] = 1'b0;
      else if (a < top) o[1] = 1'b0;
      else if (a >= 'hE0000 && f != 7) begin
        o[3] = 1'b0;
        o[2] = r ? 1'b0 : 1'b1;
      end
    end
    return o;
  endfunction

  task automatic apply(int a, bit s_n, bit r, int f, string req);
    @(posedge clk);
    #1;
    addr = a[19:0]; as_n = s_n; rw = r; fc = f[2:0];
    @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      logic [3:0] exp;
      exp = model(c, a, s_n, r, f);
      n_run++;
      if (got[c] !== exp) begin
        n_fail++;
        $display("FAIL %s cfg=%0d addr=%05h as_n=%0b rw=%0b fc=%0d actual=%04b expected=%04b",
                 req, c, a, s_n, r, f, got[c], exp);
      end
    end
  endtask

  initial begin
    addr = '0; as_n = 1'b1; rw = 1'b1; fc = 3'd5;
    // R1 idle with strobe high
    apply('h00000, 1, 1, 5, "R1");
    apply('hFFFFF, 1, 0, 6, "R1");
    apply('h08000, 1, 1, 7, "R1");
    // R2 ROM reads
    apply('hE0000, 0, 1, 5, "R2");
    apply('hF1234, 0, 1, 6, "R2");
    apply('hFFFFF, 0, 1, 1, "R2");
    apply('hFFFF4, 0, 1, 6, "R2");
    // R3 ROM writes
    apply('hE0000, 0, 0, 5, "R3");
    apply('hFFFFE, 0, 0, 1, "R3");
    // R4 acknowledge cycles per level, and other ROM addresses
    for (int lvl = 1; lvl < 8; lvl++) apply('hFFFF0 | (lvl << 1), 0, 1, 7, "R4");
    apply('hE0000, 0, 1, 7, "R4");
    apply('hE8000, 0, 0, 7, "R4");
    // R5 R6 R7 bank edges for each build
    apply('h00000, 0, 1, 5, "R5");
    apply('h07FFF, 0, 0, 1, "R5");
    apply('h00010, 0, 1, 7, "R5");
    apply('h08000, 0, 1, 5, "R6");
    apply('h0FFFF, 0, 0, 5, "R6");
    apply('h10000, 0, 1, 5, "R7");
    apply('h1FFFF, 0, 1, 5, "R7");
    apply('h20000, 0, 0, 7, "R7");
    apply('h3FFFF, 0, 1, 5, "R7");
    apply('h40000, 0, 1, 5, "R7");
    apply('h7FFFF, 0, 1, 5, "R7");
    apply('h80000, 0, 0, 5, "R7");
    apply('hDFFFF, 0, 1, 5, "R7");
    // R8 gaps
    apply('hC0000, 0, 1, 5, "R8");
    apply('hA0000, 0, 0, 5, "R8");
    // R9 mixed sweep
    begin
      int lfsr = 'h1ACE5;
      for (int i = 0; i < 400; i++) begin
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 'hB4BCD : 0);
        apply(lfsr & 'hFFFFF, (i % 9) == 0, (lfsr >> 3) & 1, (lfsr >> 5) & 7, "R9");
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule